// File: doc/BRIEF.md
# Boot Byte Feeder for an 8-bit CPU Bus

This block stands in for program memory while a CPU with an 8-bit data bus starts up. It drives the CPU clock itself, one toggle per system clock cycle. At power-up it holds the combined reset/halt line low for a fixed number of those toggles. It then answers every CPU read strobe with the next byte of a boot stream that it builds on the fly.

The stream opens with an exception vector pair: the initial stack pointer followed by the initial program counter. Next comes an instruction that loads address register A0 with the RAM base. Each 16-bit payload word is then wrapped in a store-immediate-word-with-postincrement instruction. A single NOP closes the stream, because the CPU fetches one instruction ahead of the one it executes. Payload bytes are pulled from an external source through an address/data pair, and a missing low byte at the end of an odd payload is filled with zero.

When the strobe that carries the final byte ends, the block drops its boot-mode output. This tells the memory decode to answer reads from RAM from then on. At the same time the block restarts the reset countdown, so the CPU boots again from the copy now held in RAM. While a read is being serviced, the CPU clock is frozen for a few cycles, so the data acknowledge can stay tied active.

Top module: `boot_feeder`

## Requirements
- R1: While `rst_n` is low, `boot_mode` is 1, `cpu_rst_n` is 0 and the data bus is not driven.
- R2: After `rst_n` rises, `cpu_rst_n` goes high after exactly RESET_TICKS rising edges of `clk`, counting only edges on which `cpu_clk` toggles.
- R3: `cpu_clk` toggles on every rising edge of `clk`, except for STALL_TICKS consecutive edges that begin at the edge where a served read strobe is detected. On those edges it holds its value, and the reset countdown is paused.
- R4: A fall of `ds_n` with `rw` = 1 in boot mode, after reset release, puts the next stream byte on `data` from the next `clk` edge. The byte stays there while `ds_n` is low. The bus floats from the first `clk` edge that samples `ds_n` high again.
- R5: Stream bytes 0 to 3 carry STACK_INIT and bytes 4 to 7 carry ENTRY_PC, each most significant byte first. Bytes 8 to 13 are 0x20, 0x7C and then RAM_BASE, most significant byte first.
- R6: Payload word k occupies stream bytes 14+4k to 17+4k as 0x30, 0xFC, payload[2k], payload[2k+1]. The payload byte is read from `pay_data` in the same cycle that `pay_addr` shows its index.
- R7: For an odd PAYLOAD_BYTES, the low byte of the last word is 0x00 and not a value from `pay_data`.
- R8: The last two stream bytes are 0x4E then 0x71. The stream length is 16 + 4*ceil(PAYLOAD_BYTES/2).
- R9: A strobe with `rw` = 0 is ignored. The bus is not driven, the stream position does not advance, and `cpu_clk` keeps toggling.
- R10: On the edge that sees `ds_n` rise after the final stream byte, `boot_mode` falls and `cpu_rst_n` goes low. It is released again after RESET_TICKS toggling edges. Boot mode never returns without `rst_n`.
- R11: Outside boot mode, read strobes are not answered and the bus stays undriven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| cpu_clk | output | 1 | Generated CPU clock |
| cpu_rst_n | output | 1 | Combined CPU reset/halt, active low |
| ds_n | input | 1 | CPU data strobe, active low |
| rw | input | 1 | CPU read (1) / write (0) |
| data | inout | 8 | CPU data bus, driven only for boot reads |
| boot_mode | output | 1 | High while reads are served by this block |
| pay_addr | output | AW | Index of the payload byte wanted |
| pay_data | input | 8 | Payload byte at `pay_addr` |

## Verification
The assertions assume that `rw` holds still for as long as `ds_n` is low, and that strobes arrive only when the CPU is out of reset. The bench acts as the CPU. It changes `ds_n` and `rw` together on falling clock edges, keeps each strobe low for two cycles, and starts no strobe while `cpu_rst_n` is low. It walks the complete stream of an odd-length payload, so the zero-padded byte appears. A write strobe is placed in the middle of the header, and the reboot is followed through to a further read.

// File: rtl/boot_feeder.sv
module boot_feeder #(
  parameter int          PAYLOAD_BYTES = 5,
  parameter int          RESET_TICKS   = 16,
  parameter int          STALL_TICKS   = 3,
  parameter logic [31:0] STACK_INIT    = 32'h0000_1000,
  parameter logic [31:0] ENTRY_PC      = 32'h0000_0008,
  parameter logic [31:0] RAM_BASE      = 32'h0000_0000,
  localparam int         AW            = $clog2(PAYLOAD_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          cpu_clk,
  output logic          cpu_rst_n,
  input  logic          ds_n,
  input  logic          rw,
  inout  wire  [7:0]    data,
  output logic          boot_mode,
  output logic [AW-1:0] pay_addr,
  input  logic [7:0]    pay_data
);
  localparam int WORDS    = (PAYLOAD_BYTES + 1) / 2;
  localparam int HDR      = 14;
  localparam int BODY_END = HDR + 4 * WORDS;
  localparam int LEN      = BODY_END + 2;
  localparam int PW       = $clog2(LEN + 1);
  localparam int CW       = $clog2(RESET_TICKS + 1);
  localparam int SW       = $clog2(STALL_TICKS + 1);

  logic [PW-1:0] pos, rel;
  logic [CW-1:0] rst_cnt;
  logic [SW-1:0] stall;
  logic          ds_q, drive;
  logic [7:0]    dout, next_byte;
  logic [31:0]   hword;
  logic [1:0]    hsel;

  wire fall  = ds_q & ~ds_n;
  wire rise  = ~ds_q & ds_n;
  wire serve = fall & rw & boot_mode & cpu_rst_n & (pos < PW'(LEN));
  wire hold  = serve | (stall != '0);

  assign cpu_rst_n = (rst_cnt == '0);
  assign data      = drive ? dout : 8'bz;
  assign rel       = pos - PW'(HDR);
  assign pay_addr  = AW'({rel[PW-1:2], rel[0]});

  always_comb begin
    hword = (pos < PW'(4)) ? STACK_INIT : (pos < PW'(8)) ? ENTRY_PC : RAM_BASE;
    hsel  = (pos < PW'(8)) ? pos[1:0] : 2'(pos - PW'(2));
    if (pos < PW'(8) || (pos >= PW'(10) && pos < PW'(HDR)))
      next_byte = 8'(hword >> (8 * (3 - int'(hsel))));
    else if (pos == PW'(8))
      next_byte = 8'h20;
    else if (pos == PW'(9))
      next_byte = 8'h7C;
    else if (pos < PW'(BODY_END)) begin
      case (rel[1:0])
        2'd0:    next_byte = 8'h30;
        2'd1:    next_byte = 8'hFC;
        default: next_byte = (pay_addr < AW'(PAYLOAD_BYTES)) ? pay_data : 8'h00;
      endcase
    end else
      next_byte = (pos == PW'(BODY_END)) ? 8'h4E : 8'h71;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds_q      <= 1'b1;
      drive     <= 1'b0;
      dout      <= '0;
      pos       <= '0;
      stall     <= '0;
      cpu_clk   <= 1'b0;
      boot_mode <= 1'b1;
      rst_cnt   <= CW'(RESET_TICKS);
    end else begin
      ds_q <= ds_n;
      if (stall != '0) stall <= stall - SW'(1);
      if (!hold) begin
        cpu_clk <= ~cpu_clk;
        if (rst_cnt != '0) rst_cnt <= rst_cnt - CW'(1);
      end
      if (serve) begin
        drive <= 1'b1;
        dout  <= next_byte;
        pos   <= pos + PW'(1);
        stall <= SW'(STALL_TICKS - 1);
      end
      if (rise) begin
        drive <= 1'b0;
        if (boot_mode && pos == PW'(LEN)) begin
          boot_mode <= 1'b0;
          rst_cnt   <= CW'(RESET_TICKS);
        end
      end
    end
  end

  AST_DRIVE_IN_BOOT: assert property (@(posedge clk) disable iff (!rst_n) drive |-> boot_mode);  // R11
  AST_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) drive |-> rw);  // R9
  AST_CLK_HELD: assert property (@(posedge clk) disable iff (!rst_n) (stall != '0) |=> $stable(cpu_clk));  // R3
  AST_EXIT_RESETS: assert property (@(posedge clk) disable iff (!rst_n) $fell(boot_mode) |-> !cpu_rst_n);  // R10
  AST_BOOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !boot_mode |=> !boot_mode);  // R10
  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n) !$stable(pos) |-> pos == $past(pos) + PW'(1));  // R4
  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n) pos <= PW'(LEN));  // R8
endmodule

// File: tb/sim_boot_feeder.sv
module sim_boot_feeder;
  localparam int PB = 5, RT = 16, ST = 3;
  localparam int WORDS = (PB + 1) / 2;
  localparam int BODY_END = 14 + 4 * WORDS;
  localparam int LEN = BODY_END + 2;
  localparam int AW = $clog2(PB + 1);

  logic clk = 1'b0, rst_n = 1'b0, ds_n = 1'b1, rw = 1'b1;
  logic tb_en = 1'b0;
  logic [7:0] tb_val = 8'h00;
  logic cpu_clk, cpu_rst_n, boot_mode;
  logic [AW-1:0] pay_addr;
  logic [7:0] pay_data;
  wire [7:0] bus;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;
  assign bus = tb_en ? tb_val : 8'bz;
  assign pay_data = 8'((int'(pay_addr) * 37 + 11) % 256);
  for (genvar g = 0; g < 8; g++) begin : g_pu
    pullup (bus[g]);
  end

  boot_feeder #(.PAYLOAD_BYTES(PB), .RESET_TICKS(RT), .STALL_TICKS(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
    .ds_n(ds_n), .rw(rw), .data(bus), .boot_mode(boot_mode),
    .pay_addr(pay_addr), .pay_data(pay_data));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic int exp_byte(input int i);
    int k;
    int idx;
    if (i < 4) return (32'h0000_1000 >> (8 * (3 - i))) & 255;
    if (i < 8) return (32'h0000_0008 >> (8 * (7 - i))) & 255;
    if (i == 8) return 8'h20;
    if (i == 9) return 8'h7C;
    if (i < 14) return 0;
    if (i < BODY_END) begin
      k = i - 14;
      if (k % 4 == 0) return 8'h30;
      if (k % 4 == 1) return 8'hFC;
      idx = 2 * (k / 4) + (k % 4 - 2);
      return (idx < PB) ? (idx * 37 + 11) % 256 : 0;
    end
    return (i == BODY_END) ? 8'h4E : 8'h71;
  endfunction

  function automatic string tag_of(input int i);
    if (i < 14) return "R5";
    if (i < BODY_END) return ((2 * ((i - 14) / 4) + 1) >= PB && (i - 14) % 4 == 3) ? "R7" : "R6";
    return "R8";
  endfunction

  task automatic count_release(input int expect_n, input string tag);
    int n = 0;
    bit v;
    v = cpu_clk;
    while (!cpu_rst_n && n < 200) begin
      cyc(); n++;
      check(cpu_clk == ~v, "R3", cpu_clk, ~v);
      v = cpu_clk;
    end
    check(n == expect_n, tag, n, expect_n);
  endtask

  task automatic read_one(input int i);
    bit v;
    v = cpu_clk; ds_n = 1'b0; rw = 1'b1;
    cyc();
    check(bus == 8'(exp_byte(i)), tag_of(i), bus, exp_byte(i));
    check(cpu_clk == v, "R3", cpu_clk, v);
    cyc();
    check(bus == 8'(exp_byte(i)), "R4", bus, exp_byte(i));
    ds_n = 1'b1;
    cyc();
    check(bus == 8'hFF, "R4", bus, 8'hFF);
    check(cpu_clk == v, "R3", cpu_clk, v);
    cyc();
    check(cpu_clk == ~v, "R3", cpu_clk, ~v);
  endtask

  task automatic write_one();
    bit v;
    v = cpu_clk; ds_n = 1'b0; rw = 1'b0; tb_en = 1'b1; tb_val = 8'hA5;
    cyc();
    check(bus == 8'hA5, "R9", bus, 8'hA5);
    check(cpu_clk == ~v, "R9", cpu_clk, ~v);
    ds_n = 1'b1;
    cyc();
    tb_en = 1'b0; rw = 1'b1;
    cyc();
  endtask

  initial begin
    repeat (3) cyc();
    check(boot_mode == 1'b1, "R1", boot_mode, 1);
    check(cpu_rst_n == 1'b0, "R1", cpu_rst_n, 0);
    check(bus == 8'hFF, "R1", bus, 8'hFF);
    rst_n = 1'b1;
    count_release(RT, "R2");
    for (int i = 0; i < LEN; i++) begin
      if (i == 3) write_one();
      read_one(i);
    end
    check(boot_mode == 1'b0, "R10", boot_mode, 0);
    check(cpu_rst_n == 1'b0, "R10", cpu_rst_n, 0);
    // one toggling edge of the restarted countdown already passed inside read_one
    count_release(RT - 1, "R10");
    ds_n = 1'b0; rw = 1'b1;
    cyc();
    check(bus == 8'hFF, "R11", bus, 8'hFF);
    ds_n = 1'b1;
    cyc(); cyc();
    check(boot_mode == 1'b0, "R10", boot_mode, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule